// File: doc/BRIEF.md
# Bus-Mastering Word Copy Engine

This block copies a run of words from one place in memory to another without the processor touching the data. Software sets up a source word address, a destination word address and a word count through a small register port, then writes a start bit. The engine asks for the system bus with a request line and waits for the grant. Once it holds the bus, it moves each word as a read cycle followed by a write cycle on a synchronous master port. The processor must issue no bus cycles while the grant is held.

Two pacing modes exist. In burst mode the engine keeps the bus from the first read to the last write. In cycle-stealing mode it drops its request after every word and stays off the bus for a programmable number of cycles before asking again, so the processor regains the bus between words. A slave error ends the job at once and releases the bus. The end of a job, whether normal or aborted, raises a level interrupt that software clears by writing ones to the status bits.

Register map (word index on `reg_addr`): 0 source address, 1 destination address, 2 word count, 3 control, 4 status. Control: bit 0 start (write-only), bit 1 stealing mode, bits 15:8 idle gap. Status: bit 0 busy, bit 1 done, bit 2 error. All other indices read as zero.

Top module: `dma_engine`

## Requirements
- R1: Source, destination and count read back at indices 0, 1 and 2. Writes to them, and to the mode and gap fields of the control register, take effect only while busy is 0 and are ignored while busy is 1.
- R2: Writing control with bit 0 set while idle and with a nonzero count sets busy and raises `bus_req` in the next cycle. No bus cycle is issued until `bus_gnt` has been seen high.
- R3: Each word is moved as one read cycle (`m_rd`=1, `m_addr`=source) followed in the next cycle by one write cycle (`m_wr`=1, `m_addr`=destination, `m_wdata` = the `m_rdata` captured during the read).
- R4: After each write completes without error, source and destination each increase by 1 and the count decreases by 1.
- R5: In burst mode (control bit 1 = 0), `bus_req` stays high from the grant until the last write. It falls in the cycle after that write, when done is set and busy cleared.
- R6: In stealing mode (control bit 1 = 1), `bus_req` is low for G cycles after every word except the last, where G is the gap field and a gap of 0 counts as 1. It is then raised again and must be re-granted.
- R7: A start with a count of 0 sets done in the next cycle and never raises `bus_req`.
- R8: `m_err` high during a read or write cycle ends the job. In the next cycle `bus_req` is low, busy is 0 and error is 1. Source, destination and count keep the values they had before the failing word.
- R9: `irq` equals done OR error. Writing 1 to status bit 1 or bit 2 clears that bit. An accepted start clears both.
- R10: A start written while busy is 1 is ignored.
- R11: `m_rd` and `m_wr` are never high together, and neither is high while `bus_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from `reg_addr`) |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus ownership grant |
| m_rd | output | 1 | Master read cycle |
| m_wr | output | 1 | Master write cycle |
| m_addr | output | 32 | Master word address |
| m_wdata | output | 32 | Master write data |
| m_rdata | input | 32 | Read data, valid in the read cycle |
| m_err | input | 1 | Slave error for the current cycle |
| irq | output | 1 | Completion or error interrupt |

## Verification
After a start is written, `bus_req` rises one cycle later. The read comes one cycle after the grant is seen, and the write follows in the next cycle. Counters advance and done or error appear one cycle after the cycle that caused them, and a stealing gap lasts exactly G cycles. The bench keeps its own model of phase, counters and status, advanced on each rising edge. It compares every output and the selected register readback two nanoseconds after each falling edge, once all inputs for that cycle are settled. The scenario checks then read the final register values and count the request rises.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_RD,
    ST_WR,
    ST_GAP
  } seq_state_e;

  localparam logic [2:0] RA_SRC  = 3'd0;
  localparam logic [2:0] RA_DST  = 3'd1;
  localparam logic [2:0] RA_LEN  = 3'd2;
  localparam logic [2:0] RA_CTRL = 3'd3;
  localparam logic [2:0] RA_STAT = 3'd4;

  localparam int CTRL_GO_BIT    = 0;
  localparam int CTRL_STEAL_BIT = 1;
  localparam int CTRL_GAP_LSB   = 8;

  localparam int STAT_BUSY_BIT = 0;
  localparam int STAT_DONE_BIT = 1;
  localparam int STAT_ERR_BIT  = 2;
endpackage

// File: rtl/dma_gap_timer.sv
module dma_gap_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] span,
  output logic          expired
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= span;
    else if (cnt != '0)    cnt <= cnt - ONE;
  end

  assign expired = (cnt == ONE);

  AST_TIMER_RUNS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt > ONE) |=> (cnt == $past(cnt) - ONE)); // R6
endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_pkg::*;
#(
  parameter int DW = 32,
  parameter int GW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          steal,
  input  logic [GW-1:0] gap,
  input  logic          last,
  input  logic          bus_gnt,
  input  logic          m_err,
  input  logic [DW-1:0] m_rdata,
  output seq_state_e    state_o,
  output logic          bus_req,
  output logic          m_rd,
  output logic          m_wr,
  output logic [DW-1:0] m_wdata,
  output logic          word_done,
  output logic          fin_ok,
  output logic          fin_err
);
  function automatic logic [GW-1:0] span_of(input logic [GW-1:0] g);
    return (g == '0) ? GW'(1) : g;
  endfunction

  seq_state_e    st, st_nx;
  logic [DW-1:0] data_q;
  logic          gap_load;
  logic          gap_expired;

  assign m_rd      = (st == ST_RD);
  assign m_wr      = (st == ST_WR);
  assign bus_req   = (st == ST_REQ) || (st == ST_RD) || (st == ST_WR);
  assign m_wdata   = data_q;
  assign word_done = m_wr && !m_err;
  assign fin_ok    = word_done && last;
  assign fin_err   = (m_rd || m_wr) && m_err;
  assign gap_load  = word_done && !last && steal;
  assign state_o   = st;

  dma_gap_timer #(.CW(GW)) u_gap (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (gap_load),
    .span    (span_of(gap)),
    .expired (gap_expired)
  );

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE: if (go) st_nx = ST_REQ;
      ST_REQ:  if (bus_gnt) st_nx = ST_RD;
      ST_RD:   st_nx = m_err ? ST_IDLE : ST_WR;
      ST_WR: begin
        if (m_err || last) st_nx = ST_IDLE;
        else if (steal)    st_nx = ST_GAP;
        else               st_nx = ST_RD;
      end
      ST_GAP:  if (gap_expired) st_nx = ST_REQ;
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      data_q <= '0;
    end else begin
      st <= st_nx;
      if (m_rd) data_q <= m_rdata;
    end
  end

  AST_RD_WR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(m_rd && m_wr)); // R11
  AST_CYCLE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (m_rd || m_wr) |-> bus_req); // R11
  AST_WAIT_FOR_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !m_rd && !m_wr && !bus_gnt) |=> (!m_rd && !m_wr)); // R2
  AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (m_rd && !m_err) |=> (m_wr && m_wdata == $past(m_rdata))); // R3
  AST_STEAL_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && !last && steal) |=> !bus_req); // R6
  AST_ABORT_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    fin_err |=> (!bus_req && !m_rd && !m_wr)); // R8
endmodule

// File: rtl/dma_regfile.sv
module dma_regfile
  import dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int LW = 16,
  parameter int GW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    addr,
  input  logic [DW-1:0] wdata,
  input  logic          word_done,
  input  logic          fin_ok,
  input  logic          fin_err,
  output logic [AW-1:0] src,
  output logic [AW-1:0] dst,
  output logic [LW-1:0] rem,
  output logic          steal,
  output logic [GW-1:0] gap,
  output logic          go,
  output logic          last,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [DW-1:0] rdata
);
  function automatic logic [AW-1:0] addr_step(input logic [AW-1:0] a);
    return a + AW'(1);
  endfunction

  function automatic logic [LW-1:0] count_down(input logic [LW-1:0] n);
    return n - LW'(1);
  endfunction

  logic cfg_wr;
  logic start_req;
  logic zero_start;

  assign cfg_wr     = wr_en && !busy;
  assign start_req  = cfg_wr && (addr == RA_CTRL) && wdata[CTRL_GO_BIT];
  assign go         = start_req && (rem != '0);
  assign zero_start = start_req && (rem == '0);
  assign last       = (rem == LW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src   <= '0;
      dst   <= '0;
      rem   <= '0;
      steal <= 1'b0;
      gap   <= '0;
    end else if (word_done) begin
      src <= addr_step(src);
      dst <= addr_step(dst);
      rem <= count_down(rem);
    end else if (cfg_wr) begin
      unique case (addr)
        RA_SRC:  src <= wdata[AW-1:0];
        RA_DST:  dst <= wdata[AW-1:0];
        RA_LEN:  rem <= wdata[LW-1:0];
        RA_CTRL: begin
          steal <= wdata[CTRL_STEAL_BIT];
          gap   <= wdata[CTRL_GAP_LSB +: GW];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      err  <= 1'b0;
    end else begin
      if (go)                     busy <= 1'b1;
      else if (fin_ok || fin_err) busy <= 1'b0;

      if (start_req)   done <= zero_start;
      else if (fin_ok) done <= 1'b1;
      else if (wr_en && addr == RA_STAT && wdata[STAT_DONE_BIT]) done <= 1'b0;

      if (start_req)    err <= 1'b0;
      else if (fin_err) err <= 1'b1;
      else if (wr_en && addr == RA_STAT && wdata[STAT_ERR_BIT]) err <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      RA_SRC:  rdata[AW-1:0] = src;
      RA_DST:  rdata[AW-1:0] = dst;
      RA_LEN:  rdata[LW-1:0] = rem;
      RA_CTRL: begin
        rdata[CTRL_GAP_LSB +: GW] = gap;
        rdata[CTRL_STEAL_BIT]     = steal;
      end
      RA_STAT: begin
        rdata[STAT_BUSY_BIT] = busy;
        rdata[STAT_DONE_BIT] = done;
        rdata[STAT_ERR_BIT]  = err;
      end
      default: ;
    endcase
  end

  AST_BUSY_IS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!done && !err)); // R9
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> (src == $past(src) + AW'(1) && rem == $past(rem) - LW'(1))); // R4
  AST_ZERO_LEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    zero_start |=> (done && !busy)); // R7
  AST_BUSY_LOCKS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !word_done) |=> ($stable(src) && $stable(steal) && $stable(gap))); // R1
endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int LW = 16,
  parameter int GW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [2:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic          m_rd,
  output logic          m_wr,
  output logic [AW-1:0] m_addr,
  output logic [DW-1:0] m_wdata,
  input  logic [DW-1:0] m_rdata,
  input  logic          m_err,
  output logic          irq
);
  logic [AW-1:0] src, dst;
  logic [LW-1:0] rem;
  logic [GW-1:0] gap;
  logic          steal, go, last, busy, done, err;
  logic          word_done, fin_ok, fin_err;
  seq_state_e    state;

  dma_regfile #(.AW(AW), .DW(DW), .LW(LW), .GW(GW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (reg_wr),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .word_done (word_done),
    .fin_ok    (fin_ok),
    .fin_err   (fin_err),
    .src       (src),
    .dst       (dst),
    .rem       (rem),
    .steal     (steal),
    .gap       (gap),
    .go        (go),
    .last      (last),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .rdata     (reg_rdata)
  );

  dma_seq #(.DW(DW), .GW(GW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .steal     (steal),
    .gap       (gap),
    .last      (last),
    .bus_gnt   (bus_gnt),
    .m_err     (m_err),
    .m_rdata   (m_rdata),
    .state_o   (state),
    .bus_req   (bus_req),
    .m_rd      (m_rd),
    .m_wr      (m_wr),
    .m_wdata   (m_wdata),
    .word_done (word_done),
    .fin_ok    (fin_ok),
    .fin_err   (fin_err)
  );

  assign m_addr = (state == ST_RD) ? src : dst;
  assign irq    = done || err;

  AST_DONE_OFF_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> !bus_req); // R5
  AST_ERR_OFF_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> (!bus_req && !busy)); // R8
endmodule

// File: tb/dma_engine_test.sv
module dma_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd4;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        bus_req;
  logic        bus_gnt = 1'b0;
  logic        m_rd, m_wr;
  logic [31:0] m_addr, m_wdata, m_rdata;
  logic        m_err;
  logic        irq;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int gnt_lat = 0;
  int hold = 0;
  int rises = 0;
  logic prev_req = 1'b0;
  logic err_arm = 1'b0;
  logic [31:0] err_addr = '0;

  // reference model state
  int ph = 0;            // 0 idle, 1 request, 2 read, 3 write, 4 gap
  int gcnt = 0;
  logic [31:0] msrc = '0, mdst = '0;
  logic [15:0] mrem = '0;
  logic [7:0]  mgap = '0;
  logic msteal = 0, mbusy = 0, mdone = 0, merr = 0;

  always #5 clk = ~clk;

  function automatic logic [31:0] pat(input logic [31:0] a);
    return (a * 32'd7) ^ 32'h3C00_0000;
  endfunction

  assign m_rdata = pat(m_addr);
  assign m_err   = err_arm && (m_rd || m_wr) && (m_addr == err_addr);

  dma_engine uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_req(bus_req),
    .bus_gnt(bus_gnt), .m_rd(m_rd), .m_wr(m_wr), .m_addr(m_addr),
    .m_wdata(m_wdata), .m_rdata(m_rdata), .m_err(m_err), .irq(irq)
  );

  // arbiter: grant gnt_lat cycles after request, drop with request
  always @(negedge clk) begin
    if (!bus_req) begin
      bus_gnt <= 1'b0;
      hold <= 0;
    end else begin
      if (hold >= gnt_lat) bus_gnt <= 1'b1;
      hold <= hold + 1;
    end
  end

  function automatic logic [31:0] model_read(input logic [2:0] a);
    case (a)
      3'd0: return msrc;
      3'd1: return mdst;
      3'd2: return {16'h0, mrem};
      3'd3: return {16'h0, mgap, 6'h0, msteal, 1'b0};
      3'd4: return {29'h0, merr, mdone, mbusy};
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; gcnt = 0; msrc = '0; mdst = '0; mrem = '0; mgap = '0;
      msteal = 0; mbusy = 0; mdone = 0; merr = 0;
    end else begin
      automatic logic was_busy = mbusy;
      automatic logic e = err_arm &&
        ((ph == 2 && msrc == err_addr) || (ph == 3 && mdst == err_addr));
      automatic int nph = ph;
      case (ph)
        1: if (bus_gnt) nph = 2;
        2: nph = e ? 0 : 3;
        3: if (e) nph = 0;
           else begin
             msrc = msrc + 1; mdst = mdst + 1; mrem = mrem - 1;
             if (mrem == 0) begin nph = 0; mbusy = 0; mdone = 1; end
             else if (msteal) begin nph = 4; gcnt = (mgap == 0) ? 1 : int'(mgap); end
             else nph = 2;
           end
        4: begin gcnt = gcnt - 1; if (gcnt == 0) nph = 1; end
        default: ;
      endcase
      if (e) begin mbusy = 0; merr = 1; end
      if (reg_wr) begin
        case (reg_addr)
          3'd0: if (!was_busy) msrc = reg_wdata;
          3'd1: if (!was_busy) mdst = reg_wdata;
          3'd2: if (!was_busy) mrem = reg_wdata[15:0];
          3'd3: if (!was_busy) begin
            msteal = reg_wdata[1];
            mgap   = reg_wdata[15:8];
            if (reg_wdata[0]) begin
              merr = 0;
              if (mrem == 0) mdone = 1;
              else begin mdone = 0; mbusy = 1; nph = 1; end
            end
          end
          3'd4: begin
            if (reg_wdata[1]) mdone = 0;
            if (reg_wdata[2]) merr = 0;
          end
          default: ;
        endcase
      end
      ph = nph;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // per-cycle comparison, after inputs for the cycle are settled
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      check("R2 bus_req", {31'h0, bus_req}, {31'h0, (ph == 1 || ph == 2 || ph == 3)});
      check("R3 m_rd", {31'h0, m_rd}, {31'h0, ph == 2});
      check("R3 m_wr", {31'h0, m_wr}, {31'h0, ph == 3});
      check("R9 irq", {31'h0, irq}, {31'h0, mdone | merr});
      check("R1 reg_rdata", reg_rdata, model_read(reg_addr));
      if (ph == 2) check("R4 read address", m_addr, msrc);
      if (ph == 3) begin
        check("R4 write address", m_addr, mdst);
        check("R3 write data", m_wdata, pat(msrc));
      end
      if (bus_req && !prev_req) rises++;
      prev_req = bus_req;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 3'd4; reg_wdata = '0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    check(tag, reg_rdata, exp);
    @(negedge clk);
    reg_addr = 3'd4;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // reset state
    check("R9 reset irq", {31'h0, irq}, 32'h0);
    check("R2 reset bus_req", {31'h0, bus_req}, 32'h0);
    rd_chk(3'd4, 32'h0, "R1 reset status");

    // burst, immediate grant
    gnt_lat = 0;
    wr_reg(3'd0, 32'h100); wr_reg(3'd1, 32'h200); wr_reg(3'd2, 32'd4);
    rises = 0;
    wr_reg(3'd3, 32'h1);
    idle(20);
    check("R5 burst single request", rises, 32'd1);
    rd_chk(3'd0, 32'h104, "R4 source advanced");
    rd_chk(3'd1, 32'h204, "R4 destination advanced");
    rd_chk(3'd2, 32'h0, "R4 count drained");
    rd_chk(3'd4, 32'h2, "R5 done status");
    wr_reg(3'd4, 32'h2);
    check("R9 irq cleared by write-one", {31'h0, irq}, 32'h0);

    // burst with late grant, writes while busy ignored
    gnt_lat = 3;
    wr_reg(3'd0, 32'h300); wr_reg(3'd1, 32'h400); wr_reg(3'd2, 32'd2);
    wr_reg(3'd3, 32'h1);
    wr_reg(3'd0, 32'hDEAD);
    wr_reg(3'd3, 32'h0503);
    idle(25);
    rd_chk(3'd0, 32'h302, "R1 source write while busy ignored");
    rd_chk(3'd3, 32'h0, "R10 restart while busy ignored");
    rd_chk(3'd4, 32'h2, "R5 done after late grant");
    wr_reg(3'd4, 32'h2);

    // cycle stealing, gap 4
    gnt_lat = 1;
    wr_reg(3'd0, 32'h500); wr_reg(3'd1, 32'h600); wr_reg(3'd2, 32'd3);
    rises = 0;
    wr_reg(3'd3, 32'h0403);
    idle(50);
    check("R6 one request per word", rises, 32'd3);
    rd_chk(3'd1, 32'h603, "R6 stealing destination");
    rd_chk(3'd4, 32'h2, "R6 stealing done");
    wr_reg(3'd4, 32'h2);

    // cycle stealing, gap 0 counts as 1
    gnt_lat = 0;
    wr_reg(3'd0, 32'h540); wr_reg(3'd1, 32'h640); wr_reg(3'd2, 32'd2);
    rises = 0;
    wr_reg(3'd3, 32'h0003);
    idle(20);
    check("R6 gap zero re-requests", rises, 32'd2);
    wr_reg(3'd4, 32'h2);

    // zero length
    wr_reg(3'd2, 32'd0);
    rises = 0;
    wr_reg(3'd3, 32'h1);
    rd_chk(3'd4, 32'h2, "R7 zero length done");
    idle(5);
    check("R7 zero length no request", rises, 32'd0);
    wr_reg(3'd4, 32'h2);

    // slave error on second read
    err_arm = 1'b1; err_addr = 32'h701;
    wr_reg(3'd0, 32'h700); wr_reg(3'd1, 32'h800); wr_reg(3'd2, 32'd4);
    wr_reg(3'd3, 32'h1);
    idle(20);
    rd_chk(3'd4, 32'h4, "R8 error status");
    rd_chk(3'd2, 32'd3, "R8 count kept");
    rd_chk(3'd0, 32'h701, "R8 source kept");
    check("R9 irq on error", {31'h0, irq}, 32'h1);
    err_arm = 1'b0;
    wr_reg(3'd3, 32'h1);
    idle(20);
    rd_chk(3'd4, 32'h2, "R9 start clears error");
    wr_reg(3'd4, 32'h6);
    check("R9 irq cleared", {31'h0, irq}, 32'h0);
    check("R11 bus idle at end", {30'h0, m_rd, m_wr}, 32'h0);

    idle(3);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule